// File: doc/BRIEF.md
# MSI capability register file

This block holds the message-signalled-interrupt capability structure that sits in a PCI function's configuration space. Software reaches it through a dword-addressed configuration port with per-byte enables. Through that port it reads the capability header and programs the message control word, the message address, the message data and, when the option is built in, the per-vector mask bits. A delivery engine next to the block reads the live enable, the enabled vector count, the address, the data and the mask. It also owns the pending bits, which it sets and clears through dedicated strobes.

The register layout depends on two build options. With 64-bit addressing the upper address register appears, and the data, mask and pending registers move up by one dword. Per-vector masking adds the mask and pending dwords. Bytes past the end of the capability, and dwords outside it, read as zero, and writes to them are dropped. The block clamps an oversized requested vector count when it is written. While MSI is enabled it holds the legacy INTx line low.

The block has no streaming interface. The configuration port takes one access per cycle and never applies back-pressure. Reads are combinational from the dword address. Writes take effect at the next clock edge.

Top module: `msicap_regfile`

## Requirements
- R1: The dword at the capability base reads ID 0x05 in byte 0 and the next-pointer parameter in byte 1. Bytes 2–3 hold the control word: bit 0 enable, bits 3:1 capable count (log2), bits 6:4 enabled count (log2), bit 7 set for 64-bit layout, bit 8 set when per-vector masking is built in.
- R2: In the control word only the enable bit and the enabled-count field take writes. The capable field, the 64-bit bit and the mask-capable bit ignore writes.
- R3: A write of an enabled count larger than the capable count stores the capable count.
- R4: Address-low is at base+4. Its bits 1:0 always read zero, and bits 31:2 are writable per byte.
- R5: In the 64-bit layout, address-high at base+8 is fully writable. The 16-bit data register is at base+0x0C in the 64-bit layout (base+8 otherwise). The upper 16 bits of its dword read zero.
- R6: The mask dword (base+0x10 in 64-bit layout) holds N = 2^capable writable bits 0..N-1. Its higher bits read zero.
- R7: The pending dword (base+0x14 in 64-bit layout) ignores configuration writes. Per vector, the next value is (old AND NOT clear) OR set, from the delivery-engine strobes.
- R8: intx_out follows intx_req while MSI is disabled and is held low while MSI is enabled.
- R9: Reset clears enable, the enabled count, both address registers, data, mask and pending. The read-only control fields keep their built-in values.
- R10: Writes to dwords outside the capability change nothing. Dwords outside the capability, and bytes inside the last dword past the capability length, read zero.
- R11: Only bytes whose byte enable is set are written. The delivery-engine outputs always show the stored register values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_dw_addr | input | 6 | Configuration dword address (byte address / 4) |
| cfg_be | input | 4 | Byte enables for the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for cfg_dw_addr |
| intx_req | input | 1 | Legacy interrupt request from the function |
| intx_out | output | 1 | Gated legacy interrupt line |
| pend_set | input | NVEC | Delivery engine: set pending bits |
| pend_clr | input | NVEC | Delivery engine: clear pending bits |
| msi_en | output | 1 | MSI enable |
| vec_en_log2 | output | 3 | Enabled vector count, log2 |
| msg_addr | output | 64 | Message address (upper half zero in 32-bit layout) |
| msg_data | output | 16 | Message data |
| vec_mask | output | NVEC | Per-vector mask bits |
| vec_pend | output | NVEC | Per-vector pending bits |

## Verification
The bench builds the block with 64-bit addressing, per-vector masking, a capable count of 8 vectors and the capability at byte 0x50. The 64-bit layout puts address-high, the moved data offset and the mask and pending dwords within reach. The 8-vector size leaves room both to exceed the capable count on write and to try the mask bits above N. The capability length of 0x18 ends the last dword exactly, so the data dword's dead upper half and the dwords on either side of the capability serve as the out-of-range probes.

// File: rtl/msicap_pkg.sv
package msicap_pkg;

  localparam logic [7:0] MSI_CAP_ID = 8'h05;

  typedef struct packed {
    logic       en;
    logic [2:0] qsize;
  } msicap_ctrl_t;

  // Capability length in bytes for the chosen layout
  function automatic int cap_len(input bit a64, input bit pvm);
    case ({pvm, a64})
      2'b11:   return 24;
      2'b10:   return 20;
      2'b01:   return 14;
      default: return 10;
    endcase
  endfunction

  // Dword index (relative to base) of the layout-dependent registers
  function automatic int data_dw(input bit a64);
    return a64 ? 3 : 2;
  endfunction

  function automatic int mask_dw(input bit a64);
    return a64 ? 4 : 3;
  endfunction

  function automatic int pend_dw(input bit a64);
    return a64 ? 5 : 4;
  endfunction

endpackage

// File: rtl/msicap_ctrl.sv
module msicap_ctrl
  import msicap_pkg::*;
#(
  parameter int CAP_LOG2 = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [7:0] wbyte,
  input  logic       intx_req,
  output logic       en,
  output logic [2:0] qsize,
  output logic       intx_out
);

  localparam logic [2:0] CAP3 = 3'(CAP_LOG2);

  msicap_ctrl_t st_q;
  logic [2:0]   req_q;
  logic [2:0]   clamp_q;

  always_comb begin
    req_q   = wbyte[6:4];
    clamp_q = (req_q > CAP3) ? CAP3 : req_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= '0;
    end else if (wr) begin
      st_q.en    <= wbyte[0];
      st_q.qsize <= clamp_q;
    end
  end

  assign en       = st_q.en;
  assign qsize    = st_q.qsize;
  assign intx_out = intx_req & ~st_q.en;

endmodule

// File: rtl/msicap_msgregs.sv
module msicap_msgregs #(
  parameter bit ADDR64 = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  alo_we,
  input  logic [3:0]  ahi_we,
  input  logic [1:0]  dat_we,
  input  logic [31:0] wdata,
  output logic [31:0] alo,
  output logic [31:0] ahi,
  output logic [15:0] data
);

  logic [31:0] alo_q;
  logic [31:0] alo_wd;
  logic [15:0] dat_q;

  assign alo_wd = wdata & 32'hFFFF_FFFC;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alo_q <= '0;
      dat_q <= '0;
    end else begin
      for (int b = 0; b < 4; b++) begin
        if (alo_we[b]) alo_q[8*b +: 8] <= alo_wd[8*b +: 8];
      end
      for (int b = 0; b < 2; b++) begin
        if (dat_we[b]) dat_q[8*b +: 8] <= wdata[8*b +: 8];
      end
    end
  end

  generate
    if (ADDR64) begin : g_hi
      logic [31:0] ahi_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          ahi_q <= '0;
        end else begin
          for (int b = 0; b < 4; b++) begin
            if (ahi_we[b]) ahi_q[8*b +: 8] <= wdata[8*b +: 8];
          end
        end
      end
      assign ahi = ahi_q;
    end else begin : g_nohi
      assign ahi = '0;
    end
  endgenerate

  assign alo  = alo_q;
  assign data = dat_q;

endmodule

// File: rtl/msicap_vecmask.sv
module msicap_vecmask #(
  parameter int NVEC = 32,
  parameter bit PVM  = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [3:0]      mask_we,
  input  logic [31:0]     wdata,
  input  logic [NVEC-1:0] pend_set,
  input  logic [NVEC-1:0] pend_clr,
  output logic [NVEC-1:0] mask_o,
  output logic [NVEC-1:0] pend_o
);

  generate
    if (PVM) begin : g_mask
      logic [NVEC-1:0] mask_q;
      logic [NVEC-1:0] pend_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          mask_q <= '0;
          pend_q <= '0;
        end else begin
          for (int v = 0; v < NVEC; v++) begin
            if (mask_we[v/8]) mask_q[v] <= wdata[v];
            pend_q[v] <= (pend_q[v] & ~pend_clr[v]) | pend_set[v];
          end
        end
      end
      assign mask_o = mask_q;
      assign pend_o = pend_q;
    end else begin : g_nomask
      assign mask_o = '0;
      assign pend_o = '0;
    end
  endgenerate

endmodule

// File: rtl/msicap_regfile.sv
module msicap_regfile
  import msicap_pkg::*;
#(
  parameter int         CAP_BASE     = 8'h50,
  parameter logic [7:0] NEXT_PTR     = 8'h00,
  parameter int         VEC_LOG2_CAP = 5,
  parameter bit         ADDR64       = 1'b1,
  parameter bit         PER_VEC_MASK = 1'b1,
  localparam int        NVEC         = 1 << VEC_LOG2_CAP
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [5:0]      cfg_dw_addr,
  input  logic [3:0]      cfg_be,
  input  logic [31:0]     cfg_wdata,
  output logic [31:0]     cfg_rdata,
  input  logic            intx_req,
  output logic            intx_out,
  input  logic [NVEC-1:0] pend_set,
  input  logic [NVEC-1:0] pend_clr,
  output logic            msi_en,
  output logic [2:0]      vec_en_log2,
  output logic [63:0]     msg_addr,
  output logic [15:0]     msg_data,
  output logic [NVEC-1:0] vec_mask,
  output logic [NVEC-1:0] vec_pend
);

  localparam int         LEN     = cap_len(ADDR64, PER_VEC_MASK);
  localparam logic [5:0] BASE_DW = 6'(CAP_BASE / 4);
  localparam logic [5:0] DAT_DW  = 6'(data_dw(ADDR64));
  localparam logic [5:0] MSK_DW  = 6'(mask_dw(ADDR64));
  localparam logic [5:0] PND_DW  = 6'(pend_dw(ADDR64));

  logic        hit_base;
  logic [5:0]  rel_dw;
  logic [3:0]  lane_in;
  logic [3:0]  lane_we;
  logic [31:0] alo, ahi;
  logic [15:0] ctrl16;
  logic [31:0] rd_dw;

  assign hit_base = (cfg_dw_addr >= BASE_DW);
  assign rel_dw   = cfg_dw_addr - BASE_DW;

  generate
    for (genvar i = 0; i < 4; i++) begin : g_lane
      assign lane_in[i] = hit_base && ((int'(rel_dw) * 4 + i) < LEN);
    end
  endgenerate

  assign lane_we = {4{cfg_we}} & cfg_be & lane_in;

  msicap_ctrl #(.CAP_LOG2(VEC_LOG2_CAP)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (lane_we[2] && rel_dw == 6'd0),
    .wbyte    (cfg_wdata[23:16]),
    .intx_req (intx_req),
    .en       (msi_en),
    .qsize    (vec_en_log2),
    .intx_out (intx_out)
  );

  msicap_msgregs #(.ADDR64(ADDR64)) u_msg (
    .clk    (clk),
    .rst_n  (rst_n),
    .alo_we (lane_we & {4{rel_dw == 6'd1}}),
    .ahi_we (lane_we & {4{ADDR64 && rel_dw == 6'd2}}),
    .dat_we (lane_we[1:0] & {2{rel_dw == DAT_DW}}),
    .wdata  (cfg_wdata),
    .alo    (alo),
    .ahi    (ahi),
    .data   (msg_data)
  );

  msicap_vecmask #(.NVEC(NVEC), .PVM(PER_VEC_MASK)) u_vec (
    .clk      (clk),
    .rst_n    (rst_n),
    .mask_we  (lane_we & {4{PER_VEC_MASK && rel_dw == MSK_DW}}),
    .wdata    (cfg_wdata),
    .pend_set (pend_set),
    .pend_clr (pend_clr),
    .mask_o   (vec_mask),
    .pend_o   (vec_pend)
  );

  assign msg_addr = {ahi, alo};
  assign ctrl16   = {7'b0, PER_VEC_MASK, ADDR64, vec_en_log2,
                     3'(VEC_LOG2_CAP), msi_en};

  always_comb begin
    rd_dw = '0;
    if (rel_dw == 6'd0)                           rd_dw = {ctrl16, NEXT_PTR, MSI_CAP_ID};
    else if (rel_dw == 6'd1)                      rd_dw = alo;
    else if (ADDR64 && rel_dw == 6'd2)            rd_dw = ahi;
    else if (rel_dw == DAT_DW)                    rd_dw = {16'h0, msg_data};
    else if (PER_VEC_MASK && rel_dw == MSK_DW)    rd_dw = 32'(vec_mask);
    else if (PER_VEC_MASK && rel_dw == PND_DW)    rd_dw = 32'(vec_pend);
    for (int i = 0; i < 4; i++) begin
      cfg_rdata[8*i +: 8] = lane_in[i] ? rd_dw[8*i +: 8] : 8'h00;
    end
  end

endmodule

// File: rtl/msicap_checker.sv
module msicap_checker #(
  parameter int CAP_BASE     = 8'h50,
  parameter int VEC_LOG2_CAP = 5,
  parameter bit PER_VEC_MASK = 1'b1,
  localparam int NVEC        = 1 << VEC_LOG2_CAP
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cfg_we,
  input logic [5:0]      cfg_dw_addr,
  input logic            intx_out,
  input logic [NVEC-1:0] pend_set,
  input logic [NVEC-1:0] pend_clr,
  input logic            msi_en,
  input logic [2:0]      vec_en_log2,
  input logic [63:0]     msg_addr,
  input logic [15:0]     msg_data,
  input logic [NVEC-1:0] vec_pend
);

  localparam logic [5:0] BASE_DW = 6'(CAP_BASE / 4);

  // R8
  a_r8_intx_held: assert property (@(posedge clk) disable iff (!rst_n)
    msi_en |-> !intx_out);

  // R3
  a_r3_count_clamped: assert property (@(posedge clk) disable iff (!rst_n)
    vec_en_log2 <= 3'(VEC_LOG2_CAP));

  // R4
  a_r4_addr_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    msg_addr[1:0] == 2'b00);

  // R2
  a_r2_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> ($stable(msi_en) && $stable(vec_en_log2)));

  // R7
  a_r7_pend_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_set == '0 && pend_clr == '0) |=> $stable(vec_pend));

  a_r7_pend_set: assert property (@(posedge clk) disable iff (!rst_n)
    (PER_VEC_MASK && pend_set != '0) |=> ((vec_pend & $past(pend_set)) == $past(pend_set)));

  // R10
  a_r10_outside_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_dw_addr < BASE_DW) |=>
      ($stable(msg_addr) && $stable(msg_data) && $stable(msi_en)));

endmodule

bind msicap_regfile msicap_checker #(
  .CAP_BASE     (CAP_BASE),
  .VEC_LOG2_CAP (VEC_LOG2_CAP),
  .PER_VEC_MASK (PER_VEC_MASK)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_we      (cfg_we),
  .cfg_dw_addr (cfg_dw_addr),
  .intx_out    (intx_out),
  .pend_set    (pend_set),
  .pend_clr    (pend_clr),
  .msi_en      (msi_en),
  .vec_en_log2 (vec_en_log2),
  .msg_addr    (msg_addr),
  .msg_data    (msg_data),
  .vec_pend    (vec_pend)
);

// File: tb/msicap_regfile_bench.sv
module msicap_regfile_bench;

  localparam int         PERIOD = 10;
  localparam int         BASE   = 8'h50;
  localparam logic [7:0] NXT    = 8'h70;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [5:0]  cfg_dw_addr = '0;
  logic [3:0]  cfg_be = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        intx_req = 1'b0;
  logic        intx_out;
  logic [7:0]  pend_set = '0, pend_clr = '0;
  logic        msi_en;
  logic [2:0]  vec_en_log2;
  logic [63:0] msg_addr;
  logic [15:0] msg_data;
  logic [7:0]  vec_mask, vec_pend;

  int total = 0, bad = 0;
  bit run = 0;

  // reference model state
  logic        m_en;
  logic [2:0]  m_qs;
  logic [31:0] m_alo, m_ahi;
  logic [15:0] m_data;
  logic [7:0]  m_mask, m_pend;
  logic        m_ir;

  always #(PERIOD/2) clk = ~clk;

  msicap_regfile #(.CAP_BASE(BASE), .NEXT_PTR(NXT), .VEC_LOG2_CAP(3),
                   .ADDR64(1'b1), .PER_VEC_MASK(1'b1)) u_msicap_regfile (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_dw_addr(cfg_dw_addr),
    .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .intx_req(intx_req), .intx_out(intx_out), .pend_set(pend_set),
    .pend_clr(pend_clr), .msi_en(msi_en), .vec_en_log2(vec_en_log2),
    .msg_addr(msg_addr), .msg_data(msg_data), .vec_mask(vec_mask),
    .vec_pend(vec_pend));

  function automatic void model_reset();
    m_en = 0; m_qs = 0; m_alo = 0; m_ahi = 0; m_data = 0; m_mask = 0; m_pend = 0;
  endfunction

  function automatic void model_write(input logic [5:0] a, input logic [3:0] be,
                                      input logic [31:0] wd);
    for (int i = 0; i < 4; i++) begin
      int o;
      logic [7:0] b;
      if (!be[i] || int'(a) * 4 < BASE) continue;
      o = int'(a) * 4 + i - BASE;
      b = wd[8*i +: 8];
      case (o)
        2: begin m_en = b[0]; m_qs = (b[6:4] > 3'd3) ? 3'd3 : b[6:4]; end
        4: m_alo[7:0] = b & 8'hFC;
        5, 6, 7: m_alo[8*(o-4) +: 8] = b;
        8, 9, 10, 11: m_ahi[8*(o-8) +: 8] = b;
        12, 13: m_data[8*(o-12) +: 8] = b;
        16: m_mask = b;
        default: ;
      endcase
    end
  endfunction

  function automatic logic [7:0] model_byte(input int o);
    case (o)
      0: return 8'h05;
      1: return NXT;
      2: return {1'b1, m_qs, 3'd3, m_en};
      3: return 8'h01;
      4, 5, 6, 7: return m_alo[8*(o-4) +: 8];
      8, 9, 10, 11: return m_ahi[8*(o-8) +: 8];
      12, 13: return m_data[8*(o-12) +: 8];
      16: return m_mask;
      20: return m_pend;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [31:0] model_read(input logic [5:0] a);
    logic [31:0] r = '0;
    for (int i = 0; i < 4; i++) begin
      int o = int'(a) * 4 + i - BASE;
      if (o >= 0 && o < 24) r[8*i +: 8] = model_byte(o);
    end
    return r;
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (run && rst_n) begin
      chk("R2", "msi_en", 64'(msi_en), 64'(m_en));
      chk("R3", "vec_en_log2", 64'(vec_en_log2), 64'(m_qs));
      chk("R4", "msg_addr", msg_addr, {m_ahi, m_alo});
      chk("R5", "msg_data", 64'(msg_data), 64'(m_data));
      chk("R6", "vec_mask", 64'(vec_mask), 64'(m_mask));
      chk("R7", "vec_pend", 64'(vec_pend), 64'(m_pend));
      chk("R8", "intx_out", 64'(intx_out), 64'(m_ir & ~m_en));
    end
  end

  task automatic cyc(input logic we, input logic [5:0] a, input logic [3:0] be,
                     input logic [31:0] wd, input logic [7:0] ps,
                     input logic [7:0] pc, input logic ir);
    cfg_we = we; cfg_dw_addr = a; cfg_be = be; cfg_wdata = wd;
    pend_set = ps; pend_clr = pc; intx_req = ir; m_ir = ir;
    @(posedge clk);
    #1;
    if (we) model_write(a, be, wd);
    m_pend = (m_pend & ~pc) | ps;
    #1;
  endtask

  task automatic wr(input logic [5:0] a, input logic [3:0] be, input logic [31:0] wd);
    cyc(1'b1, a, be, wd, 8'h00, 8'h00, m_ir);
  endtask

  task automatic rd(input string tag, input logic [5:0] a);
    cfg_we = 0; cfg_dw_addr = a; pend_set = 0; pend_clr = 0;
    @(negedge clk);
    chk(tag, "cfg_rdata", 64'(cfg_rdata), 64'(model_read(a)));
    @(posedge clk);
    #2;
  endtask

  localparam logic [5:0] D0 = 6'(BASE / 4);

  initial begin
    #(PERIOD * 200000);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    model_reset();
    m_ir = 0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    run = 1;
    // R9 / R1: reset values and header
    for (int k = -1; k <= 6; k++) rd("R9", 6'(int'(D0) + k));
    // R2 / R3: try to write every control bit; count 7 clamps to 3
    wr(D0, 4'b1100, 32'hFFFF_0000);
    rd("R2", D0);
    wr(D0, 4'b0100, 32'h0021_0000);
    rd("R3", D0);
    wr(D0, 4'b0100, 32'h0041_0000);
    rd("R3", D0);
    // R11: enable byte not selected, nothing changes
    wr(D0, 4'b1011, 32'h0000_FFFF);
    rd("R11", D0);
    // R4: address low
    wr(D0 + 1, 4'b1111, 32'hFFFF_FFFF);
    rd("R4", D0 + 1);
    wr(D0 + 1, 4'b0101, 32'h1234_5678);
    rd("R11", D0 + 1);
    // R5: address high and data
    wr(D0 + 2, 4'b1111, 32'hDEAD_BEEF);
    rd("R5", D0 + 2);
    wr(D0 + 3, 4'b1111, 32'hCAFE_A5C3);
    rd("R5", D0 + 3);
    // R6: mask bits above N stay zero
    wr(D0 + 4, 4'b1111, 32'hFFFF_FFFF);
    rd("R6", D0 + 4);
    wr(D0 + 4, 4'b0001, 32'h0000_005A);
    rd("R6", D0 + 4);
    // R7: pending ignores writes; strobes update it
    wr(D0 + 5, 4'b1111, 32'hFFFF_FFFF);
    rd("R7", D0 + 5);
    cyc(1'b0, D0, 4'b0, 32'h0, 8'h85, 8'h00, 1'b0);
    cyc(1'b0, D0, 4'b0, 32'h0, 8'h02, 8'h81, 1'b0);
    cyc(1'b0, D0, 4'b0, 32'h0, 8'h04, 8'h04, 1'b0);
    rd("R7", D0 + 5);
    // R8: INTx gating in both enable states
    wr(D0, 4'b0100, 32'h0000_0000);
    cyc(1'b0, D0, 4'b0, 32'h0, 8'h00, 8'h00, 1'b1);
    wr(D0, 4'b0100, 32'h0001_0000);
    cyc(1'b0, D0, 4'b0, 32'h0, 8'h00, 8'h00, 1'b1);
    cyc(1'b0, D0, 4'b0, 32'h0, 8'h00, 8'h00, 1'b0);
    // R10: outside writes ignored, outside reads zero
    wr(D0 - 1, 4'b1111, 32'hFFFF_FFFF);
    wr(D0 + 6, 4'b1111, 32'hFFFF_FFFF);
    wr(6'h3F, 4'b1111, 32'h0000_0000);
    rd("R10", D0 - 1);
    rd("R10", D0 + 6);
    rd("R10", 6'h00);
    for (int k = 0; k <= 5; k++) rd("R10", 6'(int'(D0) + k));
    // R9: reset mid-run
    cyc(1'b0, D0, 4'b0, 32'h0, 8'h10, 8'h00, 1'b0);
    run = 0;
    rst_n = 0;
    #3;
    model_reset();
    @(posedge clk);
    #2 rst_n = 1;
    run = 1;
    for (int k = 0; k <= 5; k++) rd("R9", 6'(int'(D0) + k));
    rd("R1", D0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule